// File: doc/BRIEF.md
# Doorbell-Driven Queue-Pair Work Engine

This engine lets user code hand work to a network adapter without calling the kernel. Every queue pair has a send queue and a receive queue. Each queue is a ring of descriptor slots in a descriptor RAM. Software fills one or more slots, then writes the number of new slots to that queue's doorbell. The engine adds that number to the queue's pending count. It then picks queues in rotation, reads each descriptor word by word through a synchronous RAM port, and emits the result on an output stream:

- gather segments for a normal send,
- payload words for an inline send,
- buffer address references for a receive.

After a descriptor finishes, the engine writes a completion entry if the descriptor asked for one, or if the descriptor was malformed. While the completion queue reports full, the entry is held and no further descriptor is taken. Address translation, connection setup and the link layer sit outside this block.

Top module: `qp_work_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid_o`, `cqe_valid_o` and `mem_req_o` are low.
- R2: A doorbell write adds `db_count_i` to the pending count of queue q = 2*qp + rq. Every pending descriptor is processed exactly once, in ring order, starting at slot 0. The slot index wraps modulo RING_DEPTH.
- R3: Word w of slot i of queue q is at RAM address {q, i, w}, with the word field 4 bits wide. The read data returns one cycle after `mem_req_o`. Word 0 holds the flags: bit 0 inline, bit 1 signal, bits 4:2 count.
- R4: A send descriptor without the inline flag holds count address/length word pairs. It yields count items of kind 0, each carrying an address in `out_data_o` and a length in `out_len_o`, in descriptor order.
- R5: A send descriptor with the inline flag holds count payload words. It yields count items of kind 1 carrying those words, with `out_len_o` = 0.
- R6: A receive descriptor holds count address words. It yields count items of kind 2 carrying those addresses, with `out_len_o` = 0.
- R7: A well-formed descriptor writes a completion entry only when its signal flag is set. The entry carries qp, rq, slot index and status 0. It follows the descriptor's last stream item.
- R8: A descriptor with count 0 or count above MAX_SEG yields no stream items. It always writes a completion entry with status 1.
- R9: While `cq_full_i` is high, no completion entry is written and no further descriptor read starts. The held entry is written once the signal drops.
- R10: Among queues with pending work, the next one served is the first found after the queue last served, in ascending queue number with wrap-around.
- R11: Doorbells that arrive while the engine is busy or stalled are not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| db_valid_i | input | 1 | Doorbell store strobe |
| db_qp_i | input | QP_W | Queue pair addressed by the doorbell |
| db_rq_i | input | 1 | 1 = receive queue, 0 = send queue |
| db_count_i | input | CNT_W | Number of newly posted descriptors |
| mem_req_o | output | 1 | Descriptor RAM read strobe |
| mem_addr_o | output | AW | Descriptor RAM word address |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the request |
| out_valid_o | output | 1 | Stream item valid |
| out_kind_o | output | 2 | 0 gather segment, 1 inline word, 2 receive buffer |
| out_qp_o | output | QP_W | Queue pair of the item |
| out_data_o | output | DATA_W | Address or inline payload word |
| out_len_o | output | DATA_W | Segment length (0 for kinds 1 and 2) |
| cqe_valid_o | output | 1 | Completion entry write strobe |
| cqe_qp_o | output | QP_W | Completion queue pair |
| cqe_rq_o | output | 1 | Completion queue type |
| cqe_idx_o | output | IDX_W | Slot index of the completed descriptor |
| cqe_status_o | output | 1 | 0 ok, 1 bad count |
| cq_full_i | input | 1 | Completion queue full, stalls completions |

## Verification
The assertions watch, on every cycle, the following properties:
- no pending counter rises above the ring depth or is drawn from while empty;
- every grant goes to a requesting queue other than the last one served whenever a rival is waiting;
- RAM reads never come back to back;
- a full completion queue holds the engine in place;
- a malformed descriptor produces no stream item.

Other behaviour needs the bench's scenarios, which replay descriptors against a scoreboard built from the layout rules. These cover the decoded content of gather, inline and receive descriptors, ring wrap-around, the exact rotation order after a stall, and completion entries appearing only when requested.

// File: rtl/qp_engine_pkg.sv
package qp_engine_pkg;
  typedef enum logic [1:0] {
    KIND_GATHER = 2'd0,
    KIND_INLINE = 2'd1,
    KIND_RXBUF  = 2'd2
  } item_kind_e;

  localparam int FLG_INLINE  = 0;
  localparam int FLG_SIGNAL  = 1;
  localparam int FLG_CNT_LSB = 2;
  localparam int FLG_CNT_W   = 3;

  localparam logic ST_OK  = 1'b0;
  localparam logic ST_BAD = 1'b1;
endpackage

// File: rtl/qp_db_track.sv
module qp_db_track #(
  parameter int Q          = 4,
  parameter int RING_DEPTH = 8,
  localparam int Q_W   = $clog2(Q),
  localparam int IDX_W = $clog2(RING_DEPTH),
  localparam int CNT_W = $clog2(RING_DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       db_valid_i,
  input  logic [Q_W-1:0]             db_q_i,
  input  logic [CNT_W-1:0]           db_count_i,
  input  logic                       take_i,
  input  logic [Q_W-1:0]             take_q_i,
  output logic [Q-1:0]               req_o,
  output logic [Q-1:0][IDX_W-1:0]    head_o
);
  logic [Q-1:0][CNT_W-1:0] pend_q;

  for (genvar i = 0; i < Q; i++) begin : g_queue
    logic [CNT_W-1:0] inc;
    logic             dec;
    assign inc = (db_valid_i && db_q_i == Q_W'(i)) ? db_count_i : '0;
    assign dec = take_i && take_q_i == Q_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= '0;
        head_o[i] <= '0;
      end else begin
        pend_q[i] <= pend_q[i] + inc - CNT_W'(dec);
        if (dec) head_o[i] <= head_o[i] + IDX_W'(1);
      end
    end
    assign req_o[i] = pend_q[i] != '0;

    AST_PEND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[i] <= CNT_W'(RING_DEPTH)); // R2
  end

  AST_TAKE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q[take_q_i] != '0); // R2
endmodule

// File: rtl/qp_rr_arb.sv
module qp_rr_arb #(
  parameter int Q = 4,
  localparam int Q_W = $clog2(Q)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [Q-1:0]   req_i,
  input  logic           take_i,
  output logic           gnt_valid_o,
  output logic [Q_W-1:0] gnt_q_o
);
  logic [Q_W-1:0] last_q;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_q_o     = '0;
    for (int off = 1; off <= Q; off++) begin
      int cand;
      cand = (int'(last_q) + off) % Q;
      if (!gnt_valid_o && req_i[cand]) begin
        gnt_valid_o = 1'b1;
        gnt_q_o     = Q_W'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= Q_W'(Q - 1);
    else if (take_i) last_q <= gnt_q_o;
  end

  AST_GNT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> req_i[gnt_q_o]); // R10
  AST_RR_SKIPS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && $countones(req_i) > 1) |-> gnt_q_o != last_q); // R10
endmodule

// File: rtl/qp_desc_walker.sv
module qp_desc_walker
  import qp_engine_pkg::*;
#(
  parameter int Q          = 4,
  parameter int RING_DEPTH = 8,
  parameter int DATA_W     = 32,
  parameter int MAX_SEG    = 4,
  localparam int Q_W    = $clog2(Q),
  localparam int QP_W   = Q_W - 1,
  localparam int IDX_W  = $clog2(RING_DEPTH),
  localparam int SLOT_W = $clog2(1 + 2 * MAX_SEG),
  localparam int AW     = Q_W + IDX_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_valid_i,
  input  logic [Q_W-1:0]    gnt_q_i,
  input  logic [IDX_W-1:0]  head_idx_i,
  output logic              take_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              out_valid_o,
  output logic [1:0]        out_kind_o,
  output logic [QP_W-1:0]   out_qp_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] out_len_o,
  output logic              cqe_valid_o,
  output logic [QP_W-1:0]   cqe_qp_o,
  output logic              cqe_rq_o,
  output logic [IDX_W-1:0]  cqe_idx_o,
  output logic              cqe_status_o,
  input  logic              cq_full_i
);
  typedef enum logic [2:0] {S_IDLE, S_FLAGS, S_RD, S_DAT, S_CPL} st_e;

  st_e                st;
  logic [Q_W-1:0]     cur_q;
  logic [IDX_W-1:0]   cur_idx;
  logic               inl_q, need_cpl, status_q;
  logic [SLOT_W-1:0]  wi, nwords;
  logic [DATA_W-1:0]  addr_hold;

  logic [FLG_CNT_W-1:0] f_cnt;
  logic                 f_bad, rq, gather;
  assign f_cnt  = mem_rdata_i[FLG_CNT_LSB +: FLG_CNT_W];
  assign f_bad  = (f_cnt == '0) || (int'(f_cnt) > MAX_SEG);
  assign rq     = cur_q[0];
  assign gather = !rq && !inl_q;

  assign take_o    = (st == S_IDLE) && gnt_valid_i;
  assign mem_req_o = take_o || (st == S_RD);
  assign mem_addr_o = take_o ? {gnt_q_i, head_idx_i, SLOT_W'(0)} : {cur_q, cur_idx, wi};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= S_IDLE;
      cur_q     <= '0;
      cur_idx   <= '0;
      inl_q     <= 1'b0;
      need_cpl  <= 1'b0;
      status_q  <= ST_OK;
      wi        <= '0;
      nwords    <= '0;
      addr_hold <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (gnt_valid_i) begin
          cur_q   <= gnt_q_i;
          cur_idx <= head_idx_i;
          st      <= S_FLAGS;
        end
        S_FLAGS: begin
          inl_q <= mem_rdata_i[FLG_INLINE];
          wi    <= SLOT_W'(1);
          if (f_bad) begin
            status_q <= ST_BAD;
            need_cpl <= 1'b1;
            st       <= S_CPL;
          end else begin
            status_q <= ST_OK;
            need_cpl <= mem_rdata_i[FLG_SIGNAL];
            nwords   <= (rq || mem_rdata_i[FLG_INLINE]) ? SLOT_W'(f_cnt) : SLOT_W'(2 * f_cnt);
            st       <= S_RD;
          end
        end
        S_RD: st <= S_DAT;
        S_DAT: begin
          if (gather && wi[0]) addr_hold <= mem_rdata_i;
          if (wi == nwords) st <= S_CPL;
          else begin
            wi <= wi + SLOT_W'(1);
            st <= S_RD;
          end
        end
        S_CPL: if (!need_cpl || !cq_full_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // gather emits on the length word (even index)
  assign out_valid_o = (st == S_DAT) && (!gather || !wi[0]);
  assign out_kind_o  = rq ? KIND_RXBUF : (inl_q ? KIND_INLINE : KIND_GATHER);
  assign out_qp_o    = cur_q[Q_W-1:1];
  assign out_data_o  = gather ? addr_hold : mem_rdata_i;
  assign out_len_o   = gather ? mem_rdata_i : '0;

  assign cqe_valid_o  = (st == S_CPL) && need_cpl && !cq_full_i;
  assign cqe_qp_o     = cur_q[Q_W-1:1];
  assign cqe_rq_o     = rq;
  assign cqe_idx_o    = cur_idx;
  assign cqe_status_o = status_q;

  AST_CQ_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_CPL && need_cpl && cq_full_i) |=> (st == S_CPL && !mem_req_o)); // R9
  AST_BAD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_FLAGS && f_bad) |=> !out_valid_o); // R8
  AST_MEM_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R3
endmodule

// File: rtl/qp_work_engine.sv
module qp_work_engine #(
  parameter int NUM_QP     = 2,
  parameter int RING_DEPTH = 8,
  parameter int DATA_W     = 32,
  parameter int MAX_SEG    = 4,
  localparam int QP_W   = (NUM_QP > 1) ? $clog2(NUM_QP) : 1,
  localparam int Q      = 2 * (1 << QP_W),
  localparam int Q_W    = QP_W + 1,
  localparam int IDX_W  = $clog2(RING_DEPTH),
  localparam int CNT_W  = $clog2(RING_DEPTH + 1),
  localparam int SLOT_W = $clog2(1 + 2 * MAX_SEG),
  localparam int AW     = Q_W + IDX_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              db_valid_i,
  input  logic [QP_W-1:0]   db_qp_i,
  input  logic              db_rq_i,
  input  logic [CNT_W-1:0]  db_count_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              out_valid_o,
  output logic [1:0]        out_kind_o,
  output logic [QP_W-1:0]   out_qp_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] out_len_o,
  output logic              cqe_valid_o,
  output logic [QP_W-1:0]   cqe_qp_o,
  output logic              cqe_rq_o,
  output logic [IDX_W-1:0]  cqe_idx_o,
  output logic              cqe_status_o,
  input  logic              cq_full_i
);
  logic [Q-1:0]            req;
  logic [Q-1:0][IDX_W-1:0] heads;
  logic                    gnt_valid, take;
  logic [Q_W-1:0]          gnt_q;

  qp_db_track #(.Q(Q), .RING_DEPTH(RING_DEPTH)) u_track (
    .clk_i, .rst_ni, .db_valid_i,
    .db_q_i({db_qp_i, db_rq_i}), .db_count_i,
    .take_i(take), .take_q_i(gnt_q),
    .req_o(req), .head_o(heads)
  );

  qp_rr_arb #(.Q(Q)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .take_i(take),
    .gnt_valid_o(gnt_valid), .gnt_q_o(gnt_q)
  );

  qp_desc_walker #(.Q(Q), .RING_DEPTH(RING_DEPTH), .DATA_W(DATA_W), .MAX_SEG(MAX_SEG)) u_walk (
    .clk_i, .rst_ni,
    .gnt_valid_i(gnt_valid), .gnt_q_i(gnt_q), .head_idx_i(heads[gnt_q]),
    .take_o(take), .mem_req_o, .mem_addr_o, .mem_rdata_i,
    .out_valid_o, .out_kind_o, .out_qp_o, .out_data_o, .out_len_o,
    .cqe_valid_o, .cqe_qp_o, .cqe_rq_o, .cqe_idx_o, .cqe_status_o, .cq_full_i
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!out_valid_o && !cqe_valid_o)); // R1
endmodule

// File: tb/qp_work_engine_test.sv
module qp_work_engine_test;
  localparam int NUM_QP = 2, RING = 8, DW = 32, MAXS = 4;
  localparam int QP_W = 1, IDX_W = 3, CNT_W = 4, AW = 2 + 3 + 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic db_valid = 0, db_rq = 0, cq_full = 0;
  logic [QP_W-1:0] db_qp = '0;
  logic [CNT_W-1:0] db_count = '0;
  logic mem_req, out_valid, cqe_valid, cqe_rq, cqe_status;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] rdata = '0, out_data, out_len;
  logic [1:0] out_kind;
  logic [QP_W-1:0] out_qp, cqe_qp;
  logic [IDX_W-1:0] cqe_idx;

  qp_work_engine #(.NUM_QP(NUM_QP), .RING_DEPTH(RING), .DATA_W(DW), .MAX_SEG(MAXS)) uut (
    .clk_i(clk), .rst_ni, .db_valid_i(db_valid), .db_qp_i(db_qp), .db_rq_i(db_rq),
    .db_count_i(db_count), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .out_valid_o(out_valid), .out_kind_o(out_kind), .out_qp_o(out_qp), .out_data_o(out_data),
    .out_len_o(out_len), .cqe_valid_o(cqe_valid), .cqe_qp_o(cqe_qp), .cqe_rq_o(cqe_rq),
    .cqe_idx_o(cqe_idx), .cqe_status_o(cqe_status), .cq_full_i(cq_full)
  );

  logic [DW-1:0] dmem [1 << AW];
  always @(posedge clk) if (mem_req) rdata <= dmem[mem_addr];

  int vectors = 0, fails = 0;
  int tail [4], head [4];
  logic [66:0] exp_out [$];  // {kind, qp, data, len}
  logic [5:0]  exp_cqe [$];  // {qp, rq, idx, status}

  function automatic int waddr(int q, int idx, int w);
    return (q * RING + (idx % RING)) * 16 + w;
  endfunction

  task automatic check(string req, logic [66:0] act, logic [66:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected items for the next descriptor of queue q, from the layout rules (R3..R8)
  task automatic expect_desc(int q);
    logic [DW-1:0] f;
    int cnt, idx;
    bit inl, sig, rq;
    idx = head[q] % RING;
    f = dmem[waddr(q, idx, 0)];
    inl = f[0]; sig = f[1]; cnt = int'(f[4:2]); rq = q[0];
    head[q]++;
    if (cnt == 0 || cnt > MAXS) begin
      exp_cqe.push_back({1'(q >> 1), rq, 3'(idx), 1'b1});
      return;
    end
    for (int k = 0; k < cnt; k++) begin
      if (rq)       exp_out.push_back({2'd2, 1'(q >> 1), dmem[waddr(q, idx, 1 + k)], 32'd0});
      else if (inl) exp_out.push_back({2'd1, 1'(q >> 1), dmem[waddr(q, idx, 1 + k)], 32'd0});
      else exp_out.push_back({2'd0, 1'(q >> 1), dmem[waddr(q, idx, 1 + 2*k)], dmem[waddr(q, idx, 2 + 2*k)]});
    end
    if (sig) exp_cqe.push_back({1'(q >> 1), rq, 3'(idx), 1'b0});
  endtask

  task automatic post(int q, bit inl, bit sig, int cnt, int seed);
    int idx, nw;
    idx = tail[q] % RING;
    tail[q]++;
    dmem[waddr(q, idx, 0)] = DW'({cnt[2:0], sig, inl});
    nw = (q[0] || inl) ? cnt : 2 * cnt;
    if (cnt > MAXS) nw = 0;
    for (int k = 0; k < nw; k++) dmem[waddr(q, idx, 1 + k)] = DW'(seed * 256 + k * 17 + q);
  endtask

  task automatic ring(int q, int cnt);
    @(negedge clk);
    db_valid = 1; db_qp = 1'(q >> 1); db_rq = q[0]; db_count = CNT_W'(cnt);
    @(negedge clk);
    db_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (exp_out.size() != 0 || exp_cqe.size() != 0); i++) @(negedge clk);
    repeat (12) @(negedge clk);
    vectors++;
    if (exp_out.size() != 0 || exp_cqe.size() != 0) begin
      fails++;
      $display("FAIL R2 missing items act=%0d/%0d exp=0/0", exp_out.size(), exp_cqe.size());
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_ni) begin
    if (out_valid) begin
      if (exp_out.size() == 0) check("R4/R5/R6 unexpected item", {out_kind, out_qp, out_data, out_len}, 'x);
      else check("R4/R5/R6 stream", {out_kind, out_qp, out_data, out_len}, exp_out.pop_front());
    end
    if (cqe_valid) begin
      if (exp_cqe.size() == 0) check("R7 unexpected completion", 67'({cqe_qp, cqe_rq, cqe_idx, cqe_status}), 'x);
      else check("R7/R8 completion", 67'({cqe_qp, cqe_rq, cqe_idx, cqe_status}), 67'(exp_cqe.pop_front()));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int pend [4];
    int last;
    for (int i = 0; i < (1 << AW); i++) dmem[i] = '0;
    for (int i = 0; i < 4; i++) begin tail[i] = 0; head[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset", 67'({out_valid, cqe_valid, mem_req}), 67'(0));
    rst_ni = 1;
    @(negedge clk);
    check("R1 after reset", 67'({out_valid, cqe_valid, mem_req}), 67'(0));

    // R4 R7: gather send, signalled
    post(0, 0, 1, 2, 1); expect_desc(0); ring(0, 1); drain();
    // R5 R7: inline send on qp1, not signalled
    post(2, 1, 0, 3, 2); expect_desc(2); ring(2, 1); drain();
    // R6: receive with four buffers
    post(1, 0, 1, 4, 3); expect_desc(1); ring(1, 1); drain();
    // R8: count 0 and count 5, completion despite no signal
    post(3, 0, 0, 0, 4); expect_desc(3); ring(3, 1); drain();
    post(0, 0, 0, 5, 5); expect_desc(0); ring(0, 1); drain();
    // R2: batched doorbells and ring wrap
    for (int k = 0; k < 3; k++) begin post(0, k[0], 1, k + 1, 10 + k); expect_desc(0); end
    ring(0, 3); drain();
    for (int k = 0; k < 5; k++) begin post(0, 0, k[0], 4, 20 + k); expect_desc(0); end
    ring(0, 5); drain();

    // R9 R10 R11: stall on full completion queue, then rotation order
    cq_full = 1;
    post(1, 0, 1, 1, 30); expect_desc(1); ring(1, 1);
    repeat (20) @(negedge clk);
    check("R9 stalled", 67'({cqe_valid, mem_req}), 67'(0));
    post(0, 0, 1, 1, 31); ring(0, 1);
    post(2, 1, 0, 2, 32); post(2, 0, 1, 3, 33); ring(2, 2);
    post(3, 0, 1, 2, 34); ring(3, 1);
    repeat (10) @(negedge clk);
    check("R9 no new fetch", 67'({cqe_valid, mem_req, out_valid}), 67'(0));
    pend[0] = 1; pend[1] = 0; pend[2] = 2; pend[3] = 1; last = 1;
    while (pend[0] + pend[1] + pend[2] + pend[3] > 0) begin
      for (int off = 1; off <= 4; off++) begin
        int c;
        c = (last + off) % 4;
        if (pend[c] > 0) begin
          expect_desc(c); pend[c]--; last = c;
          break;
        end
      end
    end
    @(negedge clk);
    cq_full = 0;
    drain();

    // R9: brief full pulse during a signalled stream
    post(2, 0, 1, 1, 40); expect_desc(2); ring(2, 1);
    cq_full = 1; repeat (8) @(negedge clk);
    check("R9 held entry", 67'(cqe_valid), 67'(0));
    cq_full = 0; drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule